// File: doc/BRIEF.md
# GPIO Input Debounce Filter

This block sits between the already-synchronised pad inputs of one GPIO bank and the logic that reads pin levels or raises pin interrupts. The bank is split into ports of eight pins. Each port holds one 8-bit debounce time, counted in millisecond ticks, and every pin in the port uses that time. Each pin also has its own debounce enable bit. The enable bits are written through a masked write, so software can change some pins of a port and leave the rest alone.

An enabled pin only passes a new level once the raw input has stayed at that level for the programmed number of consecutive ticks. Any change in between restarts that pin's wait. A pin whose enable is clear passes its input straight through. A pin whose port time is zero also passes its input straight through. The tick comes from outside the block as a one-cycle strobe. A build-time parameter removes the filter entirely on configurations that do not support debounce.

Top module: `gpio_debounce_bank`

## Requirements
- R1: After a synchronous reset, every port time and every enable bit reads 0, and each `pin_out` bit equals the matching `pad_in` bit.
- R2: A write to address `UPPER_OFS + 0x30 + 4*port` updates the port's enable bits. Data bits [15:8] are the mask and bits [7:0] are the new values. A pin whose mask bit is 0 keeps its enable. The enable bits read back in data bits [7:0].
- R3: A write to address `0xF0 + 4*port` sets that port's 8-bit time from data bits [7:0]. The time reads back at the same address, and each port's time is independent of the others.
- R4: For an enabled pin with time N > 0, the output takes a new input level on the Nth `ms_tick` strobe. The strobes are counted from the first clock edge after the input changed, during which the input stayed at the new level.
- R5: If the input changes again before N strobes have been seen, the count restarts. A pulse shorter than N strobes never reaches `pin_out`.
- R6: A pin whose enable bit is 0 drives `pin_out` equal to `pad_in` in the same cycle.
- R7: An enabled pin in a port whose time is 0 behaves as pass-through.
- R8: A change to the port time does not alter a wait that is already running. The new time applies from the next restart of each pin's count.
- R9: Pins are filtered independently. A disabled pin of a port passes through while another pin of the same port is still waiting.
- R10: With `DBC_SUPPORT` = 0, `pin_out` equals `pad_in`, writes have no effect, and all reads return 0.
- R11: Outside pass-through, a filtered output changes only in a cycle that carries an `ms_tick` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle strobe, once per millisecond |
| pad_in | input | NUM_PORTS*PORT_PINS | Synchronised raw pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write byte address |
| wr_data | input | 2*PORT_PINS | Register write data |
| rd_addr | input | 12 | Register read byte address |
| rd_data | output | 2*PORT_PINS | Register read data (combinational) |
| pin_out | output | NUM_PORTS*PORT_PINS | Filtered pin levels |

## Verification
The bench drives a pulse that returns to its old level and then leaves again one tick short of the limit. A filter that failed to restart would let the level through early. It changes the port time in the middle of a wait, which catches a design that reloads its limit live and fires one tick early. It checks the exact tick on which the output moves, so any off-by-one in the count shows up. It also checks that masked writes leave unmasked enables alone, that a zero time passes the input through, and that a neighbouring disabled pin tracks its input while another pin is still waiting.

// File: rtl/gdb_pkg.sv
package gdb_pkg;

    localparam int CNT_W    = 8;
    localparam int ADDR_W   = 12;
    localparam int CNT_BASE = 'hF0;
    localparam int ENA_BASE = 'h30;

    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_COUNT  = 2'd1,
        ACC_ENABLE = 2'd2
    } acc_kind_t;

    typedef struct packed {
        acc_kind_t  kind;
        logic [7:0] port;
    } acc_t;

    typedef struct packed {
        logic             held;
        logic             cand;
        logic [CNT_W-1:0] lim;
        logic [CNT_W-1:0] run;
    } pin_st_t;

    function automatic acc_t decode_addr(logic [ADDR_W-1:0] a, int upper, int nports);
        acc_t r;
        r.kind = ACC_NONE;
        r.port = '0;
        for (int p = 0; p < nports; p++) begin
            if (a == ADDR_W'(CNT_BASE + 4 * p)) begin
                r.kind = ACC_COUNT;
                r.port = 8'(p);
            end
            if (a == ADDR_W'(upper + ENA_BASE + 4 * p)) begin
                r.kind = ACC_ENABLE;
                r.port = 8'(p);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/gdb_regs.sv
module gdb_regs
    import gdb_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_PINS = 8,
    parameter int UPPER_OFS = 'h80
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [2*PORT_PINS-1:0]         wr_data,
    input  logic [ADDR_W-1:0]              rd_addr,
    output logic [2*PORT_PINS-1:0]         rd_data,
    output logic [NUM_PORTS*CNT_W-1:0]     cnt_o,
    output logic [NUM_PORTS*PORT_PINS-1:0] en_o
);
    localparam int DATA_W = 2 * PORT_PINS;
    localparam int PIDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    logic [CNT_W-1:0]     cnt_q [NUM_PORTS];
    logic [PORT_PINS-1:0] en_q  [NUM_PORTS];
    acc_t                 wdec, rdec;
    logic [PIDX_W-1:0]    widx, ridx;

    always_comb begin
        wdec = decode_addr(wr_addr, UPPER_OFS, NUM_PORTS);
        rdec = decode_addr(rd_addr, UPPER_OFS, NUM_PORTS);
        widx = wdec.port[PIDX_W-1:0];
        ridx = rdec.port[PIDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                cnt_q[p] <= '0;
                en_q[p]  <= '0;
            end
        end else if (wr_en) begin
            if (wdec.kind == ACC_COUNT)
                cnt_q[widx] <= wr_data[CNT_W-1:0];
            else if (wdec.kind == ACC_ENABLE)
                en_q[widx] <= (en_q[widx] & ~wr_data[DATA_W-1:PORT_PINS])
                            | (wr_data[PORT_PINS-1:0] & wr_data[DATA_W-1:PORT_PINS]);
        end
    end

    always_comb begin
        rd_data = '0;
        if (rdec.kind == ACC_COUNT)
            rd_data = DATA_W'(cnt_q[ridx]);
        else if (rdec.kind == ACC_ENABLE)
            rd_data = DATA_W'(en_q[ridx]);
    end

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_flat
            assign cnt_o[p*CNT_W +: CNT_W]         = cnt_q[p];
            assign en_o[p*PORT_PINS +: PORT_PINS]  = en_q[p];

            assert_en_quiet_R2: assert property (@(posedge clk) disable iff (rst)
                !wr_en |=> $stable(en_q[p]));
            assert_cnt_quiet_R3: assert property (@(posedge clk) disable iff (rst)
                !wr_en |=> $stable(cnt_q[p]));
        end
    endgenerate

endmodule

// File: rtl/gdb_pin_filter.sv
module gdb_pin_filter
    import gdb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             raw,
    input  logic             en,
    input  logic [CNT_W-1:0] cfg,
    output logic             out
);
    pin_st_t st;
    logic    byp;
    logic    reach;

    assign byp   = !en || (cfg == '0);
    assign reach = ({1'b0, st.run} + 1'b1) >= {1'b0, st.lim};

    always_ff @(posedge clk) begin
        if (rst) begin
            st.held <= raw;
            st.cand <= raw;
            st.run  <= '0;
            st.lim  <= '0;
        end else if (byp) begin
            st.held <= raw;
            st.cand <= raw;
            st.run  <= '0;
            st.lim  <= cfg;
        end else if (raw != st.cand) begin
            // level moved: restart the wait with the current port time
            st.cand <= raw;
            st.run  <= '0;
            st.lim  <= cfg;
        end else if (st.cand == st.held) begin
            // idle: keep the limit in step with the port time
            st.run <= '0;
            st.lim <= cfg;
        end else if (tick) begin
            if (reach) begin
                st.held <= st.cand;
                st.run  <= '0;
            end else begin
                st.run <= st.run + 1'b1;
            end
        end
    end

    assign out = byp ? raw : st.held;

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        st.run != {CNT_W{1'b1}});
    assert_update_on_tick_R11: assert property (@(posedge clk) disable iff (rst)
        (!byp && !tick) |=> $stable(st.held));
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!byp && st.cand == st.held) |=> $stable(st.held));

endmodule

// File: rtl/gdb_port.sv
module gdb_port
    import gdb_pkg::*;
#(
    parameter int PORT_PINS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic [PORT_PINS-1:0] raw,
    input  logic [PORT_PINS-1:0] en,
    input  logic [CNT_W-1:0]     cfg,
    output logic [PORT_PINS-1:0] out
);
    generate
        for (genvar i = 0; i < PORT_PINS; i++) begin : g_pin
            gdb_pin_filter u_pin (
                .clk  (clk),
                .rst  (rst),
                .tick (tick),
                .raw  (raw[i]),
                .en   (en[i]),
                .cfg  (cfg),
                .out  (out[i])
            );
        end
    endgenerate

endmodule

// File: rtl/gpio_debounce_bank.sv
module gpio_debounce_bank
    import gdb_pkg::*;
#(
    parameter int NUM_PORTS   = 4,
    parameter int PORT_PINS   = 8,
    parameter int UPPER_OFS   = 'h80,
    parameter bit DBC_SUPPORT = 1'b1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           ms_tick,
    input  logic [NUM_PORTS*PORT_PINS-1:0] pad_in,
    input  logic                           wr_en,
    input  logic [11:0]                    wr_addr,
    input  logic [2*PORT_PINS-1:0]         wr_data,
    input  logic [11:0]                    rd_addr,
    output logic [2*PORT_PINS-1:0]         rd_data,
    output logic [NUM_PORTS*PORT_PINS-1:0] pin_out
);
    localparam int NPINS = NUM_PORTS * PORT_PINS;

    generate
        if (DBC_SUPPORT) begin : g_dbc
            logic [NUM_PORTS*CNT_W-1:0] cnt_w;
            logic [NPINS-1:0]           en_w;

            gdb_regs #(
                .NUM_PORTS (NUM_PORTS),
                .PORT_PINS (PORT_PINS),
                .UPPER_OFS (UPPER_OFS)
            ) u_regs (
                .clk     (clk),
                .rst     (rst),
                .wr_en   (wr_en),
                .wr_addr (wr_addr),
                .wr_data (wr_data),
                .rd_addr (rd_addr),
                .rd_data (rd_data),
                .cnt_o   (cnt_w),
                .en_o    (en_w)
            );

            for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
                gdb_port #(.PORT_PINS(PORT_PINS)) u_port (
                    .clk  (clk),
                    .rst  (rst),
                    .tick (ms_tick),
                    .raw  (pad_in[p*PORT_PINS +: PORT_PINS]),
                    .en   (en_w[p*PORT_PINS +: PORT_PINS]),
                    .cfg  (cnt_w[p*CNT_W +: CNT_W]),
                    .out  (pin_out[p*PORT_PINS +: PORT_PINS])
                );
            end
        end else begin : g_plain
            assign pin_out = pad_in;
            assign rd_data = '0;
        end
    endgenerate

endmodule

// File: tb/gpio_debounce_bank_tb.sv
module gpio_debounce_bank_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ms_tick = 1'b0;
    logic [31:0] pad = '0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [15:0] rd_data, rd_data_n;
    logic [31:0] pin_out, pin_out_n;

    int  nchk = 0;
    int  nfail = 0;
    bit  done = 0;

    always #5 clk = ~clk;

    gpio_debounce_bank u_dut (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .pad_in(pad),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pin_out(pin_out));

    gpio_debounce_bank #(.DBC_SUPPORT(1'b0)) u_dut_nodbc (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .pad_in(pad),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data_n), .pin_out(pin_out_n));

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        ms_tick = 1'b1;
        @(negedge clk);
        ms_tick = 1'b0;
    endtask

    task automatic rd_check(input logic [11:0] a, input logic [15:0] exp, input string tag);
        rd_addr = a;
        #1;
        check(rd_data == exp, tag, 32'(rd_data), 32'(exp));
    endtask

    task automatic t_reset_R1();
        rd_check(12'h0F0, 16'h0000, "R1 count port0");
        rd_check(12'h0B4, 16'h0000, "R1 enable port1");
        step(); pad = 32'hA5A5_5A5A; #1;
        check(pin_out == pad, "R1 out follows pad", pin_out, pad);
        step(); pad = '0; step();
    endtask

    task automatic t_bypass_R6();
        step(); pad = 32'h0000_00C3; #1;
        check(pin_out == 32'h0000_00C3, "R6 disabled same cycle", pin_out, 32'h0000_00C3);
        step(); pad = '0; step();
    endtask

    task automatic t_mask_R2();
        wr(12'h0B0, 16'h0F05);
        rd_check(12'h0B0, 16'h0005, "R2 first masked write");
        wr(12'h0B0, 16'hF0FF);
        rd_check(12'h0B0, 16'h00F5, "R2 unmasked bits kept");
    endtask

    task automatic t_count_R3();
        wr(12'h0F4, 16'h0003);
        wr(12'h0F0, 16'h0004);
        rd_check(12'h0F4, 16'h0003, "R3 port1 time");
        rd_check(12'h0F0, 16'h0004, "R3 port0 time");
    endtask

    task automatic t_filter_R4_R9();
        step(); pad[0] = 1'b1; pad[1] = 1'b1;
        step();
        #1;
        check(pin_out[1] == 1'b1, "R9 disabled neighbour passes", 32'(pin_out[1]), 1);
        for (int k = 0; k < 3; k++) tick();
        #1;
        check(pin_out[0] == 1'b0, "R4 held before Nth tick", 32'(pin_out[0]), 0);
        check(pin_out_n[0] == 1'b1, "R10 no-filter build passes", 32'(pin_out_n[0]), 1);
        tick(); #1;
        check(pin_out[0] == 1'b1, "R4 changes on Nth tick", 32'(pin_out[0]), 1);
        pad[1] = 1'b0;
    endtask

    task automatic t_glitch_R5();
        step(); pad[0] = 1'b0; step();
        for (int k = 0; k < 3; k++) tick();
        #1;
        check(pin_out[0] == 1'b1, "R5 short pulse blocked", 32'(pin_out[0]), 1);
        step(); pad[0] = 1'b1; step();
        step(); pad[0] = 1'b0; step();
        for (int k = 0; k < 3; k++) tick();
        #1;
        check(pin_out[0] == 1'b1, "R5 count restarted", 32'(pin_out[0]), 1);
        tick(); #1;
        check(pin_out[0] == 1'b0, "R5 full wait after restart", 32'(pin_out[0]), 0);
    endtask

    task automatic t_zero_R7();
        wr(12'h0F4, 16'h0000);
        wr(12'h0B4, 16'h0101);
        step(); pad[8] = 1'b1; #1;
        check(pin_out[8] == 1'b1, "R7 zero time passes", 32'(pin_out[8]), 1);
        step(); pad[8] = 1'b0; #1;
        check(pin_out[8] == 1'b0, "R7 zero time passes low", 32'(pin_out[8]), 0);
    endtask

    task automatic t_newcount_R8();
        step(); pad[0] = 1'b1; step();
        tick(); tick();
        wr(12'h0F0, 16'h0002);
        tick(); #1;
        check(pin_out[0] == 1'b0, "R8 running wait keeps old time", 32'(pin_out[0]), 0);
        tick(); #1;
        check(pin_out[0] == 1'b1, "R8 old time completes", 32'(pin_out[0]), 1);
        step(); pad[0] = 1'b0; step();
        tick(); #1;
        check(pin_out[0] == 1'b1, "R8 new time not yet", 32'(pin_out[0]), 1);
        tick(); #1;
        check(pin_out[0] == 1'b0, "R8 new time applies", 32'(pin_out[0]), 0);
    endtask

    task automatic t_nodbc_R10();
        rd_addr = 12'h0F0; #1;
        check(rd_data_n == 16'h0000, "R10 reads zero", 32'(rd_data_n), 0);
        check(pin_out_n == pad, "R10 output equals pad", pin_out_n, pad);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_R1();
        t_bypass_R6();
        t_mask_R2();
        t_count_R3();
        t_filter_R4_R9();
        t_glitch_R5();
        t_zero_R7();
        t_newcount_R8();
        t_nodbc_R10();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule